// File: doc/BRIEF.md
# Stochastic Leaky Integrate-and-Fire Neuron Core

This block models one spiking neuron whose membrane potential lives in a 16-bit register. Every enabled cycle it first drains a programmable leak from the potential and then adds a weighted drive. Both steps clamp, so the potential never wraps below zero or above full scale. The drive is an unsigned value multiplied by an unsigned weight. A select bit picks whether the drive comes from parallel input pins or from a value held in configuration.

A spike is allowed only when three things hold together: the potential is at or above the programmed threshold, an externally generated random permit bit is high, and the neuron is not recovering from a previous spike. Each spike appears as a one-cycle pulse. The same clock edge zeroes the potential and loads a recovery counter with a 3-bit programmable length. While that counter is nonzero, the neuron neither integrates nor fires. The output rate is therefore capped at one spike per (length + 1) cycles.

Control is a two-state machine. `ST_INTEG` integrates and may fire. `ST_REFRACT` counts recovery cycles. The transition `fire_to_refract` is taken on a spike with a nonzero length. `fire_stay` is taken on a spike with a length of zero. `refract_done` is taken when the counter steps from 1 to 0. A low enable freezes every piece of state. The random source and any register access sit outside this block.

Top module: `nrn_core`

## Requirements
- R1: A synchronous active-high reset sets the membrane to 0, clears the refractory flag and drives the spike output to 0. This holds whatever the other inputs are.
- R2: In an integrating cycle the next membrane is computed from the current membrane in two steps. First it becomes max(membrane − leak, 0). Then the weighted drive is added. The leak always comes first, so membrane 20 with leak 50 and drive product 10 gives 10.
- R3: The addition clamps at 65535 instead of wrapping.
- R4: When enabled, not refractory, membrane ≥ threshold and permit = 1, the next cycle shows spike = 1 for exactly that cycle with the membrane at 0.
- R5: With permit = 0 no spike occurs, even when the membrane is above threshold, and integration continues.
- R6: A spike loads the recovery length L (0–7). The refractory flag is then high for exactly L cycles, counting the cycle that shows the spike. During those cycles there is no spike and the membrane does not change.
- R7: With L = 0 and threshold 0 a spike occurs every cycle. With L = 2 spikes occur every third cycle.
- R8: The drive product is pin_drive × weight when drive_sel = 0 and cfg_drive × weight when drive_sel = 1. The unselected source has no effect.
- R9: While en = 0 the membrane and the refractory counter hold their values and spike is 0.
- R10: Over a fixed window, a larger weight or a lower threshold gives a strictly higher spike count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes all state |
| drive_sel | input | 1 | 0 selects pin_drive, 1 selects cfg_drive |
| pin_drive | input | 8 | Drive from parallel pins |
| cfg_drive | input | 8 | Drive from a configuration value |
| weight | input | 8 | Unsigned synaptic weight |
| leak | input | 16 | Amount drained each integrating cycle |
| threshold | input | 16 | Firing threshold (inclusive) |
| refr_len | input | 3 | Recovery length in cycles, 0 to 7 |
| permit | input | 1 | Random fire-permit bit |
| spike | output | 1 | One-cycle spike pulse |
| membrane | output | 16 | Current membrane potential |
| refr_busy | output | 1 | High while the recovery counter is nonzero |

## Verification
Several properties are checked on every cycle. Each spike must follow a cycle in which all four firing conditions held. A spike always shows a zero membrane. The refractory flag agrees with the loaded length. A refractory or disabled cycle is followed by no spike and an unchanged membrane. The exact arithmetic is shown only by the bench's directed scenarios: the ordering of leak before add, clamping at both ends, source selection and the spike period for a given length. The same goes for monotonic rate control, which the bench measures by counting spikes over long windows.

// File: rtl/nrn_pkg.sv
package nrn_pkg;

    typedef enum logic [0:0] {
        ST_INTEG   = 1'b0,
        ST_REFRACT = 1'b1
    } nrn_state_e;

    localparam int unsigned NRN_MEM_W  = 16;
    localparam int unsigned NRN_DRV_W  = 8;
    localparam int unsigned NRN_WGT_W  = 8;
    localparam int unsigned NRN_REF_W  = 3;

endpackage

// File: rtl/nrn_drive_sel.sv
module nrn_drive_sel #(
    parameter int unsigned DRV_W = 8,
    parameter int unsigned WGT_W = 8,
    parameter int unsigned MEM_W = 16
) (
    input  logic             drive_sel,
    input  logic [DRV_W-1:0] pin_drive,
    input  logic [DRV_W-1:0] cfg_drive,
    input  logic [WGT_W-1:0] weight,
    output logic [MEM_W-1:0] inc
);
    localparam int unsigned PROD_W = DRV_W + WGT_W;

    logic [DRV_W-1:0]  drv;
    logic [PROD_W-1:0] prod;

    always_comb begin
        drv  = drive_sel ? cfg_drive : pin_drive;
        prod = PROD_W'(drv) * PROD_W'(weight);
    end

    generate
        if (PROD_W <= MEM_W) begin : g_fit
            assign inc = MEM_W'(prod);
        end else begin : g_clamp
            assign inc = (|prod[PROD_W-1:MEM_W]) ? {MEM_W{1'b1}} : prod[MEM_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/nrn_sat_step.sv
module nrn_sat_step #(
    parameter int unsigned MEM_W = 16
) (
    input  logic [MEM_W-1:0] mem_cur,
    input  logic [MEM_W-1:0] leak,
    input  logic [MEM_W-1:0] inc,
    output logic [MEM_W-1:0] mem_next
);
    logic [MEM_W-1:0] drained;
    logic [MEM_W:0]   sum;

    always_comb begin
        drained  = (mem_cur > leak) ? (mem_cur - leak) : '0;
        sum      = {1'b0, drained} + {1'b0, inc};
        mem_next = sum[MEM_W] ? {MEM_W{1'b1}} : sum[MEM_W-1:0];
    end

endmodule

// File: rtl/nrn_refr_fsm.sv
module nrn_refr_fsm
    import nrn_pkg::*;
#(
    parameter int unsigned REF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fire_req,
    input  logic [REF_W-1:0] refr_len,
    output logic             fire,
    output logic             hold_mem,
    output logic             busy
);
    nrn_state_e       state_q;
    logic [REF_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INTEG;
            cnt_q   <= '0;
        end else if (en) begin
            unique case (state_q)
                ST_INTEG: begin
                    if (fire_req) begin
                        cnt_q <= refr_len;
                        if (refr_len != '0) begin
                            state_q <= ST_REFRACT;   // fire_to_refract
                        end else begin
                            state_q <= ST_INTEG;     // fire_stay
                        end
                    end
                end
                ST_REFRACT: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == REF_W'(1)) begin
                        state_q <= ST_INTEG;         // refract_done
                    end
                end
                default: begin
                    state_q <= ST_INTEG;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        fire     = 1'b0;
        hold_mem = 1'b1;
        busy     = 1'b0;
        unique case (state_q)
            ST_INTEG: begin
                fire     = en && fire_req;
                hold_mem = !en;
            end
            ST_REFRACT: begin
                busy     = 1'b1;
                hold_mem = 1'b1;
            end
            default: begin
                hold_mem = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nrn_core.sv
module nrn_core
    import nrn_pkg::*;
#(
    parameter int unsigned MEM_W = NRN_MEM_W,
    parameter int unsigned DRV_W = NRN_DRV_W,
    parameter int unsigned WGT_W = NRN_WGT_W,
    parameter int unsigned REF_W = NRN_REF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             drive_sel,
    input  logic [DRV_W-1:0] pin_drive,
    input  logic [DRV_W-1:0] cfg_drive,
    input  logic [WGT_W-1:0] weight,
    input  logic [MEM_W-1:0] leak,
    input  logic [MEM_W-1:0] threshold,
    input  logic [REF_W-1:0] refr_len,
    input  logic             permit,
    output logic             spike,
    output logic [MEM_W-1:0] membrane,
    output logic             refr_busy
);
    logic [MEM_W-1:0] mem_q;
    logic             spike_q;
    logic [MEM_W-1:0] inc;
    logic [MEM_W-1:0] mem_next;
    logic             fire_req;
    logic             fire;
    logic             hold_mem;
    logic             busy;

    nrn_drive_sel #(
        .DRV_W (DRV_W),
        .WGT_W (WGT_W),
        .MEM_W (MEM_W)
    ) u_drive (
        .drive_sel (drive_sel),
        .pin_drive (pin_drive),
        .cfg_drive (cfg_drive),
        .weight    (weight),
        .inc       (inc)
    );

    nrn_sat_step #(
        .MEM_W (MEM_W)
    ) u_step (
        .mem_cur  (mem_q),
        .leak     (leak),
        .inc      (inc),
        .mem_next (mem_next)
    );

    assign fire_req = (mem_q >= threshold) && permit;

    nrn_refr_fsm #(
        .REF_W (REF_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fire_req (fire_req),
        .refr_len (refr_len),
        .fire     (fire),
        .hold_mem (hold_mem),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q   <= '0;
            spike_q <= 1'b0;
        end else begin
            spike_q <= fire;
            if (fire) begin
                mem_q <= '0;
            end else if (!hold_mem) begin
                mem_q <= mem_next;
            end
        end
    end

    always_comb begin
        spike     = spike_q;
        membrane  = mem_q;
        refr_busy = busy;
    end

endmodule

// File: rtl/nrn_core_chk.sv
module nrn_core_chk #(
    parameter int unsigned MEM_W = 16,
    parameter int unsigned REF_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             permit,
    input logic [MEM_W-1:0] threshold,
    input logic [REF_W-1:0] refr_len,
    input logic             spike,
    input logic [MEM_W-1:0] membrane,
    input logic             refr_busy
);
    // R4
    spike_cause_chk: assert property (@(posedge clk) disable iff (rst)
        spike |-> $past(en && permit && !refr_busy && (membrane >= threshold)));

    // R4
    spike_zero_mem_chk: assert property (@(posedge clk) disable iff (rst)
        spike |-> (membrane == '0));

    // R6
    refr_load_chk: assert property (@(posedge clk) disable iff (rst)
        spike |-> (refr_busy == ($past(refr_len) != '0)));

    // R6
    refr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        refr_busy |=> (!spike && $stable(membrane)));

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!spike && $stable(membrane) && $stable(refr_busy)));

endmodule

bind nrn_core nrn_core_chk #(
    .MEM_W (MEM_W),
    .REF_W (REF_W)
) u_nrn_core_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .permit    (permit),
    .threshold (threshold),
    .refr_len  (refr_len),
    .spike     (spike),
    .membrane  (membrane),
    .refr_busy (refr_busy)
);

// File: tb/nrn_core_bench.sv
module nrn_core_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        dsel = 1'b0;
    logic        permit = 1'b0;
    logic [7:0]  pd = '0;
    logic [7:0]  cd = '0;
    logic [7:0]  wt = '0;
    logic [15:0] lk = '0;
    logic [15:0] th = 16'hFFFF;
    logic [2:0]  rf = '0;

    logic        spike;
    logic [15:0] mem;
    logic        busy;

    nrn_core u_nrn_core (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .drive_sel (dsel),
        .pin_drive (pd),
        .cfg_drive (cd),
        .weight    (wt),
        .leak      (lk),
        .threshold (th),
        .refr_len  (rf),
        .permit    (permit),
        .spike     (spike),
        .membrane  (mem),
        .refr_busy (busy)
    );

    typedef struct packed {
        logic        spk;
        logic [15:0] mem;
        logic        busy;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    string req = "R1";
    int    total = 0;
    int    bad = 0;
    int    spk_seen = 0;
    bit    done = 1'b0;

    logic [15:0] m_mem = '0;
    logic [2:0]  m_cnt = '0;
    logic        m_spk = 1'b0;

    // driver: reference model from the requirements, one expected item per cycle
    task automatic tick();
        logic [15:0] inc;
        logic [15:0] lv;
        logic [16:0] s;
        exp_t        e;
        inc = 16'(dsel ? cd : pd) * 16'(wt);
        if (rst) begin
            m_mem = '0; m_cnt = '0; m_spk = 1'b0;
        end else if (!en) begin
            m_spk = 1'b0;
        end else if (m_cnt != 0) begin
            m_cnt = m_cnt - 1'b1;
            m_spk = 1'b0;
        end else if (m_mem >= th && permit) begin
            m_spk = 1'b1; m_mem = '0; m_cnt = rf;
        end else begin
            m_spk = 1'b0;
            lv    = (m_mem > lk) ? m_mem - lk : 16'd0;
            s     = {1'b0, lv} + {1'b0, inc};
            m_mem = s[16] ? 16'hFFFF : s[15:0];
        end
        e.spk = m_spk; e.mem = m_mem; e.busy = (m_cnt != 0);
        q.push_back(e);
        tq.push_back(req);
        @(negedge clk);
    endtask

    // monitor: pop and compare after each active edge
    initial begin
        exp_t  e;
        string r;
        forever begin
            @(posedge clk);
            #2;
            if (spike === 1'b1) spk_seen++;
            if (q.size() > 0) begin
                e = q.pop_front();
                r = tq.pop_front();
                total++;
                if ({spike, mem, busy} !== e) begin
                    bad++;
                    $display("FAIL %s: spike/mem/busy actual %b/%0d/%b expected %b/%0d/%b",
                             r, spike, mem, busy, e.spk, e.mem, e.busy);
                end
            end
        end
    end

    task automatic check(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a;
        int b;
        int c;
        int s0;
        @(negedge clk);
        // R1: reset with active-looking inputs
        req = "R1"; rst = 1; en = 1; pd = 50; wt = 50; permit = 1; th = 0;
        repeat (3) tick();
        // R8: pin source, then configuration source
        rst = 0; permit = 0; th = 16'hFFFF; dsel = 0; pd = 3; cd = 99; wt = 5; lk = 0;
        req = "R8"; repeat (4) tick();
        dsel = 1; cd = 7; pd = 200; repeat (3) tick();
        // R2: leak floor and leak-before-add
        req = "R2"; dsel = 0; pd = 0; lk = 100; repeat (3) tick();
        pd = 4; wt = 5; lk = 0; tick();
        lk = 50; pd = 2; tick();
        // R3: clamp at full scale
        req = "R3"; lk = 0; pd = 255; wt = 255; repeat (3) tick();
        lk = 1000; tick();
        // R5: above threshold, no permit
        req = "R5"; th = 1000; permit = 0; lk = 0; pd = 1; wt = 1; repeat (3) tick();
        // R9: disabled hold
        req = "R9"; en = 0; pd = 255; repeat (3) tick();
        // R4: fire with recovery length 3
        req = "R4"; en = 1; permit = 1; rf = 3; pd = 0; tick();
        // R6: refractory window then re-integrate and fire
        req = "R6"; rf = 0; pd = 255; repeat (5) tick();
        // R9: counter frozen while disabled during recovery
        req = "R9"; th = 0; rf = 4; tick();
        en = 0; repeat (3) tick();
        en = 1; repeat (5) tick();
        // R7: rate cap
        req = "R7"; rf = 0; repeat (8) tick();
        rf = 2; repeat (9) tick();
        // R1: reset in mid-run
        req = "R1"; rst = 1; tick();
        rst = 0;
        // R10: monotonic rate control
        req = "R10"; th = 200; permit = 1; rf = 0; lk = 0; dsel = 0; pd = 1; wt = 2;
        s0 = spk_seen; repeat (200) tick(); a = spk_seen - s0;
        wt = 8;
        s0 = spk_seen; repeat (200) tick(); b = spk_seen - s0;
        wt = 2; th = 50;
        s0 = spk_seen; repeat (200) tick(); c = spk_seen - s0;
        check(b > a, "R10 weight", b, a + 1);
        check(c > a, "R10 threshold", c, a + 1);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule